// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block sits between a local request port and a host bridge's configuration-cycle machinery. A requester hands over one configuration read or write at a time: a target bus number, a device/function pair, a register offset, write data and an access size. The sequencer first validates the request. It then computes the address inside the configuration window and writes the target bus number into the bus field of its control word. Before each cycle it clears a sticky pair of completion flags (done and error). It holds the cycle until the bus side reports completion and then returns a status with read data.

Malformed requests and requests for slots the bridge cannot reach finish with no bus cycle. On bus 0 the visible slots sit six slot positions above the requested ones. The bridge's own configuration header is reached with a dedicated "self" flag. Configuration data travels little-endian on the bus, so every 32-bit word is byte-reversed in both directions. A byte or halfword write is done as a read of the aligned word, a merge of the new lanes, and a write of the word back. A failed read ends that write with no write cycle.

Top module: `pcicfg_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. Each accepted request produces exactly one single-cycle `rsp_valid` pulse, and no new request is taken before that pulse.
- R2: Access size encoding: 0 = byte, 1 = halfword, 2 = word, 3 = reserved. The request ends with status 1 (invalid), `rsp_rdata` = 0 and no bus cycle if any of these holds: any offset bit above bit 7 is set; the size is reserved; a halfword has offset bit 0 set; a word has offset bits 1:0 nonzero. A byte access has no alignment rule.
- R3: Except for self requests, a device/function whose slot field (bits 7:3) exceeds 15 ends with status 2 (master abort) and no bus cycle. A read then returns all ones in its size (0xFF, 0xFFFF or 0xFFFFFFFF), and a write returns 0.
- R4: A self request uses bus 0 with device/function 0. On bus 0 the device/function has 0x30 added. On any other bus it is used unchanged.
- R5: The cycle address is `CFG_BASE` OR (translated device/function << 8) OR (offset bits 7:2 << 2).
- R6: Before each cycle, bits 23:16 of `ctrl_word` take the target bus number. All other bits of `ctrl_word` keep their reset value `CTRL_RST`.
- R7: The done and error flags are cleared before every bus cycle, so an error left over from an earlier cycle never affects a later request.
- R8: `cyc_req` stays high with a stable address and write data until `cyc_done`. If `cyc_err` accompanied `cyc_done`, the request ends with status 2, and a read returns all ones in its size.
- R9: Write data is byte-reversed onto `cyc_wdata`, and `cyc_rdata` is byte-reversed before use.
- R10: A successful read returns status 0. The result is the lane of the byte-reversed word starting at byte offset bits 1:0, zero-extended for byte and halfword sizes.
- R11: A byte or halfword write issues a read of the aligned word and then a write of that word. The new lane is merged at a shift of 8 × offset bits 1:0. If the read aborts, no write cycle is issued and the status is 2.
- R12: A word write issues exactly one write cycle. Every write returns `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_self | input | 1 | Access the bridge's own configuration header |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device (7:3) and function (2:0) |
| req_offset | input | OFS_W | Register byte offset |
| req_wdata | input | 32 | Write data, right-aligned for sub-word sizes |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 invalid, 2 master abort |
| rsp_rdata | output | 32 | Read result |
| ctrl_word | output | 32 | Control word holding the bus field in bits 23:16 |
| cyc_req | output | 1 | Configuration cycle requested |
| cyc_write | output | 1 | Cycle is a write |
| cyc_addr | output | 32 | Cycle address in the configuration window |
| cyc_wdata | output | 32 | Cycle write data, bus byte order |
| cyc_done | input | 1 | Cycle completed (one-cycle pulse) |
| cyc_err | input | 1 | Cycle ended in master abort, valid with `cyc_done` |
| cyc_rdata | input | 32 | Cycle read data, bus byte order, valid with `cyc_done` |

## Verification
Directed requests are aimed at each translation case: a bus-0 device, the bridge itself, and a device on another bus. Comparing their cycle addresses tells the six-slot shift apart from the plain path. Malformed offsets, the reserved size, slot 16 and devices with function 7 (which the bus model aborts) each end early. Counting bus cycles tells a rejection before the bus from an abort on it. An abort followed at once by a good request exposes any stale error flag. Random reads and writes of all sizes and offsets against a bus-order memory model then cover lane selection, merge position and the byte reversal.

// File: rtl/pcicfg_pkg.sv
`timescale 1ns/1ps
package pcicfg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_INVALID = 2'd1,
    ST_MABORT  = 2'd2
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_SETUP,
    S_CYCLE,
    S_WAIT,
    S_RESP
  } state_e;

  // reverse the four bytes of a word
  function automatic logic [31:0] f_bswap(input logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      r[8*k +: 8] = w[8*(3-k) +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] f_size_mask(input size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // lane of a host-order word starting at byte sel, zero-extended
  function automatic logic [31:0] f_extract(input logic [31:0] w, input size_e sz,
                                            input logic [1:0] sel);
    logic [31:0] sh;
    sh = w >> {sel, 3'b000};
    return sh & f_size_mask(sz);
  endfunction

  // place data lanes into a host-order word at byte sel
  function automatic logic [31:0] f_merge(input logic [31:0] w, input logic [31:0] d,
                                          input size_e sz, input logic [1:0] sel);
    logic [31:0] m;
    m = f_size_mask(sz) << {sel, 3'b000};
    return (w & ~m) | ((d << {sel, 3'b000}) & m);
  endfunction

endpackage

// File: rtl/pcicfg_reqchk.sv
`timescale 1ns/1ps
module pcicfg_reqchk
  import pcicfg_pkg::*;
#(
  parameter int          OFS_W      = 12,
  parameter logic [31:0] CFG_BASE   = 32'hC001_0000,
  parameter int          BUS0_SLOTS = 6,
  parameter int          MAX_SLOT   = 15
) (
  input  logic             self_acc,
  input  logic [7:0]       bus,
  input  logic [7:0]       devfn,
  input  logic [OFS_W-1:0] offset,
  input  size_e            size,
  output logic             bad_req,
  output logic             slot_abort,
  output logic [7:0]       tgt_bus,
  output logic [7:0]       tgt_devfn,
  output logic [31:0]      tgt_addr
);
  localparam logic [7:0] DEVFN_ADD = 8'(BUS0_SLOTS * 8);
  localparam logic [4:0] SLOT_LIM  = 5'(MAX_SLOT);

  logic hi_bad;
  logic align_bad;

  generate
    if (OFS_W > 8) begin : g_hi
      assign hi_bad = |offset[OFS_W-1:8];
    end else begin : g_nohi
      assign hi_bad = 1'b0;
    end
  endgenerate

  always_comb begin
    case (size)
      SZ_BYTE: align_bad = 1'b0;
      SZ_HALF: align_bad = offset[0];
      SZ_WORD: align_bad = |offset[1:0];
      default: align_bad = 1'b1;
    endcase
  end

  assign bad_req    = hi_bad | align_bad;
  assign slot_abort = !self_acc && (devfn[7:3] > SLOT_LIM);

  always_comb begin
    if (self_acc) begin
      tgt_bus   = 8'd0;
      tgt_devfn = 8'd0;
    end else if (bus == 8'd0) begin
      tgt_bus   = 8'd0;
      tgt_devfn = devfn + DEVFN_ADD;
    end else begin
      tgt_bus   = bus;
      tgt_devfn = devfn;
    end
  end

  assign tgt_addr = CFG_BASE | {16'd0, tgt_devfn, 8'd0} | {24'd0, offset[7:2], 2'b00};

endmodule

// File: rtl/pcicfg_flags.sv
`timescale 1ns/1ps
module pcicfg_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic done_in,
  input  logic err_in,
  output logic done_flag,
  output logic err_flag
);
  // sticky completion pair; clear wins over a same-cycle set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else if (clr) begin
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else if (done_in) begin
      done_flag <= 1'b1;
      if (err_in) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/pcicfg_lanes.sv
`timescale 1ns/1ps
module pcicfg_lanes
  import pcicfg_pkg::*;
(
  input  logic [31:0] bus_rd,
  input  logic [31:0] host_wr,
  input  logic [31:0] wdata,
  input  size_e       size,
  input  logic [1:0]  sel,
  output logic [31:0] rd_lane,
  output logic [31:0] merged,
  output logic [31:0] ones_lane,
  output logic [31:0] bus_wr
);
  logic [31:0] host_rd;

  assign host_rd   = f_bswap(bus_rd);
  assign rd_lane   = f_extract(host_rd, size, sel);
  assign merged    = f_merge(host_rd, wdata, size, sel);
  assign ones_lane = f_extract(32'hFFFF_FFFF, size, sel);
  assign bus_wr    = f_bswap(host_wr);
endmodule

// File: rtl/pcicfg_seq.sv
`timescale 1ns/1ps
module pcicfg_seq
  import pcicfg_pkg::*;
#(
  parameter int          OFS_W      = 12,
  parameter logic [31:0] CFG_BASE   = 32'hC001_0000,
  parameter logic [31:0] CTRL_RST   = 32'h0600_0000,
  parameter int          BUS0_SLOTS = 6,
  parameter int          MAX_SLOT   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_self,
  input  logic [1:0]       req_size,
  input  logic [7:0]       req_bus,
  input  logic [7:0]       req_devfn,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [31:0]      rsp_rdata,
  output logic [31:0]      ctrl_word,
  output logic             cyc_req,
  output logic             cyc_write,
  output logic [31:0]      cyc_addr,
  output logic [31:0]      cyc_wdata,
  input  logic             cyc_done,
  input  logic             cyc_err,
  input  logic [31:0]      cyc_rdata
);
  localparam int BUS_LSB = 16;
  localparam int BUS_W   = 8;

  state_e           state_q;
  logic             r_write, r_self;
  size_e            r_size;
  logic [7:0]       r_bus, r_devfn;
  logic [OFS_W-1:0] r_ofs;
  logic [31:0]      r_wdata;
  logic [31:0]      word_q, rd_q, rdata_q, ctrl_q;
  logic [1:0]       status_q;
  logic             rmw_rd_q;

  // named internal events
  logic        accept;
  logic        clr_flags;
  logic        flag_done, flag_err;
  logic        chk_bad, chk_slot;
  logic [7:0]  tgt_bus, tgt_devfn;
  logic [31:0] tgt_addr;
  logic [31:0] rd_lane, merged, ones_lane, bus_wr;

  assign accept    = (state_q == S_IDLE) && req_valid;
  assign clr_flags = (state_q == S_SETUP);

  pcicfg_reqchk #(
    .OFS_W(OFS_W), .CFG_BASE(CFG_BASE), .BUS0_SLOTS(BUS0_SLOTS), .MAX_SLOT(MAX_SLOT)
  ) u_chk_req (
    .self_acc(r_self), .bus(r_bus), .devfn(r_devfn), .offset(r_ofs), .size(r_size),
    .bad_req(chk_bad), .slot_abort(chk_slot), .tgt_bus(tgt_bus),
    .tgt_devfn(tgt_devfn), .tgt_addr(tgt_addr)
  );

  pcicfg_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr(clr_flags), .done_in(cyc_done && cyc_req),
    .err_in(cyc_err), .done_flag(flag_done), .err_flag(flag_err)
  );

  pcicfg_lanes u_lanes (
    .bus_rd(rd_q), .host_wr(word_q), .wdata(r_wdata), .size(r_size), .sel(r_ofs[1:0]),
    .rd_lane(rd_lane), .merged(merged), .ones_lane(ones_lane), .bus_wr(bus_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      r_write  <= 1'b0;
      r_self   <= 1'b0;
      r_size   <= SZ_BYTE;
      r_bus    <= '0;
      r_devfn  <= '0;
      r_ofs    <= '0;
      r_wdata  <= '0;
      word_q   <= '0;
      rd_q     <= '0;
      rdata_q  <= '0;
      status_q <= ST_OK;
      rmw_rd_q <= 1'b0;
      ctrl_q   <= CTRL_RST;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            r_write <= req_write;
            r_self  <= req_self;
            r_size  <= size_e'(req_size);
            r_bus   <= req_bus;
            r_devfn <= req_devfn;
            r_ofs   <= req_offset;
            r_wdata <= req_wdata;
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (chk_bad) begin
            status_q <= ST_INVALID;
            rdata_q  <= '0;
            state_q  <= S_RESP;
          end else if (chk_slot) begin
            status_q <= ST_MABORT;
            rdata_q  <= r_write ? 32'd0 : ones_lane;
            state_q  <= S_RESP;
          end else begin
            rmw_rd_q <= r_write && (r_size != SZ_WORD);
            word_q   <= r_wdata;
            state_q  <= S_SETUP;
          end
        end
        S_SETUP: begin
          ctrl_q[BUS_LSB +: BUS_W] <= tgt_bus;
          state_q <= S_CYCLE;
        end
        S_CYCLE: begin
          if (cyc_done) begin
            rd_q    <= cyc_rdata;
            state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (flag_done) begin
            if (flag_err) begin
              status_q <= ST_MABORT;
              rdata_q  <= r_write ? 32'd0 : ones_lane;
              state_q  <= S_RESP;
            end else if (rmw_rd_q) begin
              word_q   <= merged;
              rmw_rd_q <= 1'b0;
              state_q  <= S_SETUP;
            end else begin
              status_q <= ST_OK;
              rdata_q  <= r_write ? 32'd0 : rd_lane;
              state_q  <= S_RESP;
            end
          end
        end
        S_RESP:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == S_IDLE);
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = status_q;
  assign rsp_rdata  = rdata_q;
  assign ctrl_word  = ctrl_q;
  assign cyc_req    = (state_q == S_CYCLE);
  assign cyc_write  = r_write && !rmw_rd_q;
  assign cyc_addr   = tgt_addr;
  assign cyc_wdata  = bus_wr;

endmodule

// File: rtl/pcicfg_seq_chk.sv
`timescale 1ns/1ps
module pcicfg_seq_chk #(
  parameter logic [31:0] CFG_BASE = 32'hC001_0000,
  parameter logic [31:0] CTRL_RST = 32'h0600_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [31:0] rsp_rdata,
  input logic [31:0] ctrl_word,
  input logic        cyc_req,
  input logic [31:0] cyc_addr,
  input logic [31:0] cyc_wdata,
  input logic        cyc_done,
  input logic        clr_flags,
  input logic        flag_done,
  input logic        flag_err
);
  localparam logic [31:0] BUS_FIELD = 32'h00FF_0000;
  localparam logic [31:0] WIN_MASK  = 32'hFFFF_0000;

  p_one_at_a_time_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_invalid_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |-> (rsp_rdata == 32'd0));

  p_addr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> (((cyc_addr & WIN_MASK) == (CFG_BASE & WIN_MASK)) && (cyc_addr[1:0] == 2'b00)));

  p_ctrl_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word & ~BUS_FIELD) == (CTRL_RST & ~BUS_FIELD));

  p_flags_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags |=> (!flag_done && !flag_err));

  p_hold_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && !cyc_done) |=> (cyc_req && $stable(cyc_addr) && $stable(cyc_wdata)));

  p_no_rsp_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> !rsp_valid);
endmodule

bind pcicfg_seq pcicfg_seq_chk #(.CFG_BASE(CFG_BASE), .CTRL_RST(CTRL_RST)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .ctrl_word(ctrl_word),
  .cyc_req(cyc_req), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .cyc_done(cyc_done),
  .clr_flags(clr_flags), .flag_done(flag_done), .flag_err(flag_err)
);

// File: tb/sim_pcicfg_seq.sv
`timescale 1ns/1ps
module sim_pcicfg_seq;
  localparam int          OFS_W    = 12;
  localparam logic [31:0] CFG_BASE = 32'hC001_0000;
  localparam logic [31:0] CTRL_RST = 32'h0600_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_self = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [7:0] req_bus = 8'd0, req_devfn = 8'd0;
  logic [OFS_W-1:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, cyc_req, cyc_write;
  logic [1:0] rsp_status;
  logic [31:0] rsp_rdata, ctrl_word, cyc_addr, cyc_wdata;
  logic cyc_done = 1'b0, cyc_err = 1'b0;
  logic [31:0] cyc_rdata = '0;

  int checks = 0, errors = 0, cycles = 0;
  int n_cyc = 0, n_wr = 0, addr_bad = 0, bus_bad = 0, rsp_cnt = 0, dly = 0;
  logic [31:0] exp_addr = '0;
  logic [7:0]  exp_bus = '0;
  logic [31:0] mem [bit [31:0]];

  always #5 clk = ~clk;

  pcicfg_seq #(.OFS_W(OFS_W), .CFG_BASE(CFG_BASE), .CTRL_RST(CTRL_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_self(req_self), .req_size(req_size), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .ctrl_word(ctrl_word), .cyc_req(cyc_req), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .cyc_wdata(cyc_wdata), .cyc_done(cyc_done), .cyc_err(cyc_err), .cyc_rdata(cyc_rdata)
  );

  function automatic logic [31:0] mem_get(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A3C_9617;
  endfunction

  function automatic logic [31:0] b_rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic int b_bytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] b_lane(input logic [31:0] w, input int sz, input int sel);
    logic [31:0] r = '0;
    for (int k = 0; k < b_bytes(sz); k++) r[8*k +: 8] = w[8*(sel+k) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] b_put(input logic [31:0] w, input logic [31:0] d,
                                        input int sz, input int sel);
    logic [31:0] r = w;
    for (int k = 0; k < b_bytes(sz); k++) r[8*(sel+k) +: 8] = d[8*k +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // bus cycle model: aborts any device whose function number is 7
  initial begin
    forever begin
      @(negedge clk);
      if (cyc_done) begin
        cyc_done = 1'b0;
        cyc_err  = 1'b0;
      end else if (cyc_req && rst_n) begin
        if (dly > 0) dly--;
        else begin
          n_cyc++;
          if (cyc_addr != exp_addr) addr_bad++;
          if (ctrl_word[23:16] != exp_bus) bus_bad++;
          cyc_err = (cyc_addr[10:8] == 3'b111);
          if (cyc_write) begin
            n_wr++;
            if (!cyc_err) mem[cyc_addr] = cyc_wdata;
          end
          cyc_rdata = cyc_err ? $urandom : mem_get(cyc_addr);
          cyc_done  = 1'b1;
          dly = $urandom % 3;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) rsp_cnt++;
    end
  end

  task automatic do_req(input bit wr, input bit slf, input int sz, input logic [7:0] bus,
                        input logic [7:0] devfn, input logic [OFS_W-1:0] ofs,
                        input logic [31:0] wd);
    bit bad, slot, berr;
    logic [7:0] edf, ebus;
    logic [31:0] a, host, newv, xr;
    int xst, xcyc, xwr, t, rc0;
    string tg;
    bad  = (ofs > 255) || (sz == 3) || (sz == 1 && ofs[0]) || (sz == 2 && ofs[1:0] != 0);
    slot = !slf && (devfn >= 8'd128);
    edf  = slf ? 8'd0 : (bus == 0 ? devfn + 8'd48 : devfn);
    ebus = slf ? 8'd0 : bus;
    a    = CFG_BASE + {16'd0, edf, 8'd0} + {24'd0, ofs[7:2], 2'b00};
    berr = (edf[2:0] == 3'd7);
    host = b_rev(mem_get(a));
    newv = host;
    if (bad) begin
      tg = "R2"; xst = 1; xcyc = 0; xwr = 0; xr = 0;
    end else if (slot) begin
      tg = "R3"; xst = 2; xcyc = 0; xwr = 0; xr = wr ? 0 : b_lane(32'hFFFF_FFFF, sz, 0);
    end else if (berr) begin
      tg = "R8"; xst = 2; xcyc = 1; xwr = (wr && sz == 2) ? 1 : 0;
      xr = wr ? 0 : b_lane(32'hFFFF_FFFF, sz, 0);
      if (wr && sz != 2) tg = "R11";
    end else if (wr) begin
      tg = (sz == 2) ? "R12" : "R11"; xst = 0; xr = 0;
      xcyc = (sz == 2) ? 1 : 2; xwr = 1;
      newv = (sz == 2) ? wd : b_put(host, wd, sz, int'(ofs[1:0]));
    end else begin
      tg = (sz == 2) ? "R9" : "R10"; xst = 0; xcyc = 1; xwr = 0;
      xr = b_lane(host, sz, int'(ofs[1:0]));
    end
    exp_addr = a; exp_bus = ebus;
    n_cyc = 0; n_wr = 0; addr_bad = 0; bus_bad = 0; rc0 = rsp_cnt;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_self = slf; req_size = 2'(sz);
    req_bus = bus; req_devfn = devfn; req_offset = ofs; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R1", 32'(req_ready), 32'd0);
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(rsp_valid == 1'b1, "R1", 32'(rsp_valid), 32'd1);
    chk(rsp_status == 2'(xst), tg, 32'(rsp_status), 32'(xst));
    chk(rsp_rdata == xr, tg, rsp_rdata, xr);
    chk(n_cyc == xcyc, tg, 32'(n_cyc), 32'(xcyc));
    chk(n_wr == xwr, (wr && sz != 2) ? "R11" : "R12", 32'(n_wr), 32'(xwr));
    if (xcyc > 0) begin
      chk(addr_bad == 0, "R5", 32'(addr_bad), 32'd0);
      chk(bus_bad == 0, "R6", 32'(bus_bad), 32'd0);
    end
    if (wr && xst == 0) chk(mem_get(a) == b_rev(newv), "R9", mem_get(a), b_rev(newv));
    @(negedge clk);
    chk(rsp_cnt - rc0 == 1, "R1", 32'(rsp_cnt - rc0), 32'd1);
  endtask

  initial begin
    int r;
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0 && cyc_req == 1'b0, "R1", 32'(rsp_valid), 32'd0);
    chk(ctrl_word == CTRL_RST, "R6", ctrl_word, CTRL_RST);

    do_req(0, 0, 2, 8'd0, 8'h08, 12'h000, 0);    // R4 bus-0 shift
    do_req(0, 1, 2, 8'd9, 8'h55, 12'h034, 0);    // R4 self access
    do_req(0, 0, 2, 8'd3, 8'h21, 12'h010, 0);    // R4 other bus, R6 field
    do_req(0, 0, 2, 8'd1, 8'h08, 12'h102, 0);    // R2 high offset bit
    do_req(0, 0, 1, 8'd1, 8'h08, 12'h011, 0);    // R2 odd halfword
    do_req(0, 0, 3, 8'd1, 8'h08, 12'h010, 0);    // R2 reserved size
    do_req(0, 0, 0, 8'd1, 8'h08, 12'h013, 0);    // R10 byte any offset
    do_req(0, 0, 2, 8'd4, 8'h80, 12'h000, 0);    // R3 slot 16 word read
    do_req(0, 0, 0, 8'd4, 8'hF9, 12'h001, 0);    // R3 byte read
    do_req(1, 0, 2, 8'd4, 8'h80, 12'h000, 1);    // R3 write
    do_req(0, 0, 2, 8'd2, 8'h17, 12'h000, 0);    // R8 bus abort
    do_req(0, 0, 2, 8'd2, 8'h10, 12'h000, 0);    // R7 next request unaffected
    do_req(1, 0, 2, 8'd2, 8'h10, 12'h020, 32'h1122_3344); // R12 / R9
    a = CFG_BASE | 32'h0000_1020;
    chk(mem_get(a) == 32'h4433_2211, "R9", mem_get(a), 32'h4433_2211);
    do_req(0, 0, 2, 8'd2, 8'h10, 12'h020, 0);
    chk(rsp_rdata == 32'h1122_3344, "R9", rsp_rdata, 32'h1122_3344);
    do_req(1, 0, 0, 8'd2, 8'h10, 12'h021, 32'h0000_00AB); // R11 byte
    do_req(0, 0, 2, 8'd2, 8'h10, 12'h020, 0);
    chk(rsp_rdata == 32'h1122_AB44, "R11", rsp_rdata, 32'h1122_AB44);
    do_req(1, 0, 1, 8'd2, 8'h10, 12'h022, 32'h0000_BEEF); // R11 half
    do_req(1, 0, 0, 8'd2, 8'h0F, 12'h008, 32'h0000_0077); // R11 read abort
    do_req(0, 0, 2, 8'd2, 8'h10, 12'h000, 0);             // R7 after abort

    for (int i = 0; i < 300; i++) begin
      int rs, sz;
      logic [OFS_W-1:0] o;
      logic [7:0] b;
      rs = $urandom % 10;
      sz = (rs < 1) ? 3 : (rs < 4) ? 0 : (rs < 7) ? 1 : 2;
      o = ($urandom % 16 < 15) ? OFS_W'($urandom % 256) : OFS_W'($urandom);
      if ($urandom % 10 < 9) begin
        if (sz == 2) o[1:0] = 2'b00;
        if (sz == 1) o[0] = 1'b0;
      end
      case ($urandom % 4)
        0: b = 8'd0;
        1: b = 8'd1;
        2: b = 8'd2;
        default: b = 8'd5;
      endcase
      do_req(1'($urandom % 2), ($urandom % 10) == 0, sz, b, 8'($urandom % 160), o, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule